// File: doc/BRIEF.md
# Block-Matching Search Micro-Sequencer

This block steers a motion search for one macroblock by running a short program held in a 64-word by 16-bit instruction store. The host loads the store through a plain write port and pulses `start`. The sequencer then fetches one instruction at a time. An evaluate instruction forms a candidate vector from the committed best vector plus a signed offset. It sends that candidate to an external SAD engine and takes the SAD back. A keep instruction commits the best candidate seen so far. A halt instruction ends the search.

Two sets of registers hold the state of the search. The pending set holds the smallest SAD seen and the vector that produced it. The committed set is the base for later offsets and is what the result outputs show. Because offsets are relative to the committed vector, a cross search, a three-step search or any hand-written pattern fits in the same store. A candidate that falls outside the ±16 pixel window is dropped and the engine is not called for it.

The SAD engine interface is a valid/ready pair in each direction, with at most one request outstanding. After raising `req_valid`, the sequencer holds the candidate steady until `req_ready` is seen. It then raises `resp_ready` and waits any number of cycles for `resp_valid`. Either side may stall for as long as it likes.

Top module: `bm_search_seq`

## Requirements
- R1: Each instruction word is laid out as follows: opcode in bits [15:14] (00 evaluate, 01 keep, 10 halt, 11 no-op), two reserved bits [13:12] that must be zero, a two's-complement x offset in [11:6] and a two's-complement y offset in [5:0]. The host writes a word at `prog_addr` whenever `prog_we` is high.
- R2: A `start` pulse while idle does four things: it clears `done`, sets the committed and pending vectors to (0,0) with SAD all ones, restarts at address 0, and raises `busy` at the next edge. A `start` pulse while busy is ignored.
- R3: Evaluate sends the committed vector plus the offset on `req_x`/`req_y`, with `req_valid` high. The vector stays stable until `req_ready` is high at a clock edge.
- R4: An evaluate candidate whose x or y lies outside -16..+16 is skipped, and no request is issued for it.
- R5: A returned SAD replaces the pending best only when it is strictly smaller. On equal SAD the earlier candidate stays.
- R6: Keep copies the pending vector and SAD into the committed registers. `best_x`, `best_y` and `best_sad` show only the committed values.
- R7: Halt returns the block to idle. `busy` falls, `done` stays high until the next accepted start, and `done_pulse` is high for exactly one cycle.
- R8: When the instruction at address 63 is not halt, the search ends after it exactly as if halt had followed.
- R9: Opcode 11, and any instruction with a nonzero reserved field, executes as a no-op and issues no request.
- R10: After reset the block is idle. `done`, `req_valid` and `resp_ready` are low, and the results read (0,0) with SAD all ones.
- R11: `resp_ready` is high only while a response is awaited, never together with `req_valid`. Exactly one response is consumed per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_we | input | 1 | Instruction store write enable |
| prog_addr | input | 6 | Instruction store write address |
| prog_data | input | 16 | Instruction word to write |
| start | input | 1 | Begin a search for a new macroblock |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search complete, waiting for host |
| done_pulse | output | 1 | One-cycle completion pulse |
| req_valid | output | 1 | Candidate request valid |
| req_ready | input | 1 | SAD engine accepts the candidate |
| req_x | output | 6 | Candidate x, two's complement |
| req_y | output | 6 | Candidate y, two's complement |
| resp_valid | input | 1 | SAD result valid |
| resp_ready | output | 1 | Sequencer waits for a SAD result |
| resp_sad | input | 16 | SAD of the last candidate |
| best_x | output | 6 | Committed best x |
| best_y | output | 6 | Committed best y |
| best_sad | output | 16 | Committed best SAD |

## Verification
Each program runs against an engine model whose cost is a bowl with its minimum at (3,-2). This makes a wrong base vector, a missed commit or a skipped comparison show up as a different final vector and SAD. Some programs evaluate a good candidate but never commit it, which separates committed results from pending ones. Others place candidates just past the window or relative to a far committed base, and a count of requests shows that the window test uses absolute positions. A pair of equal-cost candidates shows the tie rule. No-op and reserved-bit words, a program with no halt, and a second start during a run cover the control corners. The model stalls its ready and response by varying amounts throughout, so back-pressure is exercised in every program.

// File: rtl/bm_seq_pkg.sv
package bm_seq_pkg;

  typedef enum logic [1:0] {
    OP_EVAL = 2'b00,
    OP_KEEP = 2'b01,
    OP_HALT = 2'b10,
    OP_NOP  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_REQ,
    ST_RESP
  } st_e;

  localparam int OFF_W   = 6;
  localparam int INSTR_W = 16;

  typedef struct packed {
    logic [1:0]       op;
    logic [1:0]       rsv;
    logic [OFF_W-1:0] dx;
    logic [OFF_W-1:0] dy;
  } instr_t;

endpackage

// File: rtl/bm_prog_ram.sv
module bm_prog_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/bm_cand_calc.sv
module bm_cand_calc #(
  parameter int VW  = 6,
  parameter int OW  = 6,
  parameter int LIM = 16
) (
  input  logic [1:0][VW-1:0] base,
  input  logic [1:0][OW-1:0] off,
  output logic [1:0][VW-1:0] cand,
  output logic               in_range
);
  localparam int EW = ((VW > OW) ? VW : OW) + 1;

  logic [1:0] axis_ok;

  for (genvar a = 0; a < 2; a++) begin : g_axis
    logic signed [EW-1:0] sum;
    assign sum        = EW'($signed(base[a])) + EW'($signed(off[a]));
    assign axis_ok[a] = (sum >= -LIM) && (sum <= LIM);
    assign cand[a]    = sum[VW-1:0];
  end

  assign in_range = &axis_ok;
endmodule

// File: rtl/bm_best_track.sv
module bm_best_track #(
  parameter int VW = 6,
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          ev_valid,
  input  logic [VW-1:0] ev_x,
  input  logic [VW-1:0] ev_y,
  input  logic [SW-1:0] ev_sad,
  input  logic          commit,
  output logic [VW-1:0] com_x,
  output logic [VW-1:0] com_y,
  output logic [SW-1:0] com_sad
);
  logic [VW-1:0] pend_x, pend_y;
  logic [SW-1:0] pend_sad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_x   <= '0;
      pend_y   <= '0;
      pend_sad <= '1;
    end else if (init) begin
      pend_x   <= '0;
      pend_y   <= '0;
      pend_sad <= '1;
    end else if (ev_valid && (ev_sad < pend_sad)) begin
      pend_x   <= ev_x;
      pend_y   <= ev_y;
      pend_sad <= ev_sad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      com_x   <= '0;
      com_y   <= '0;
      com_sad <= '1;
    end else if (init) begin
      com_x   <= '0;
      com_y   <= '0;
      com_sad <= '1;
    end else if (commit) begin
      com_x   <= pend_x;
      com_y   <= pend_y;
      com_sad <= pend_sad;
    end
  end

  // R6: a commit never makes the stored best worse
  assert_commit_monotone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !init) |=> (com_sad <= $past(com_sad)));

  // R5: the pending SAD only moves down until the next init
  assert_pending_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !$past(init)) |-> (pend_sad <= $past(pend_sad)));
endmodule

// File: rtl/bm_search_seq.sv
module bm_search_seq
  import bm_seq_pkg::*;
#(
  parameter int AW  = 6,
  parameter int VW  = 6,
  parameter int SW  = 16,
  parameter int LIM = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [15:0]   prog_data,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          done_pulse,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [VW-1:0] req_x,
  output logic [VW-1:0] req_y,
  input  logic          resp_valid,
  output logic          resp_ready,
  input  logic [SW-1:0] resp_sad,
  output logic [VW-1:0] best_x,
  output logic [VW-1:0] best_y,
  output logic [SW-1:0] best_sad
);
  localparam logic [AW-1:0] PC_LAST = '1;

  st_e               st;
  logic [AW-1:0]     pc;
  logic [INSTR_W-1:0] rd_word;
  instr_t            instr;
  op_e               op;
  logic              rsv_set;
  logic [1:0][VW-1:0] cand;
  logic              cand_ok;
  logic              adv, fin, init, ev_valid, commit;

  bm_prog_ram #(.AW(AW), .DW(INSTR_W)) u_ram (
    .clk     (clk),
    .wr_en   (prog_we),
    .wr_addr (prog_addr),
    .wr_data (prog_data),
    .rd_en   (st == ST_FETCH),
    .rd_addr (pc),
    .rd_data (rd_word)
  );

  assign instr   = instr_t'(rd_word);
  assign rsv_set = |instr.rsv;
  assign op      = rsv_set ? OP_NOP : op_e'(instr.op);

  bm_cand_calc #(.VW(VW), .OW(OFF_W), .LIM(LIM)) u_cand (
    .base     ({best_y, best_x}),
    .off      ({instr.dy, instr.dx}),
    .cand     (cand),
    .in_range (cand_ok)
  );

  always_comb begin
    adv = 1'b0;
    if (st == ST_DECODE) begin
      case (op)
        OP_EVAL: adv = !cand_ok;
        OP_HALT: adv = 1'b0;
        default: adv = 1'b1;
      endcase
    end else if (st == ST_RESP) begin
      adv = resp_valid;
    end
  end

  assign fin      = ((st == ST_DECODE) && (op == OP_HALT)) || (adv && (pc == PC_LAST));
  assign init     = (st == ST_IDLE) && start;
  assign ev_valid = (st == ST_RESP) && resp_valid;
  assign commit   = (st == ST_DECODE) && (op == OP_KEEP);

  bm_best_track #(.VW(VW), .SW(SW)) u_best (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (init),
    .ev_valid (ev_valid),
    .ev_x     (req_x),
    .ev_y     (req_y),
    .ev_sad   (resp_sad),
    .commit   (commit),
    .com_x    (best_x),
    .com_y    (best_y),
    .com_sad  (best_sad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      pc         <= '0;
      done       <= 1'b0;
      done_pulse <= 1'b0;
      req_x      <= '0;
      req_y      <= '0;
    end else begin
      done_pulse <= 1'b0;
      if (fin) begin
        st         <= ST_IDLE;
        done       <= 1'b1;
        done_pulse <= 1'b1;
      end else if (adv) begin
        pc <= pc + AW'(1);
        st <= ST_FETCH;
      end else begin
        case (st)
          ST_IDLE: if (start) begin
            pc   <= '0;
            done <= 1'b0;
            st   <= ST_FETCH;
          end
          ST_FETCH: st <= ST_DECODE;
          ST_DECODE: if (op == OP_EVAL && cand_ok) begin
            req_x <= cand[0];
            req_y <= cand[1];
            st    <= ST_REQ;
          end
          ST_REQ: if (req_ready) st <= ST_RESP;
          default: ;
        endcase
      end
    end
  end

  assign busy       = (st != ST_IDLE);
  assign req_valid  = (st == ST_REQ);
  assign resp_ready = (st == ST_RESP);

  // R3: request held stable under back-pressure
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_x) && $stable(req_y)));

  // R4: no request leaves the search window
  assert_req_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($signed(req_x) >= -LIM && $signed(req_x) <= LIM &&
                   $signed(req_y) >= -LIM && $signed(req_y) <= LIM));

  // R7: done and busy never together; pulse lasts one cycle
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R2: busy only rises from an accepted start
  assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R11: awaiting a response excludes an open request
  assert_resp_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    resp_ready |-> !req_valid);
  assert_resp_after_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resp_ready) |-> $past(req_valid && req_ready));
endmodule

// File: tb/bm_search_seq_test.sv
module bm_search_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [5:0] prog_addr = '0;
  logic [15:0] prog_data = '0;
  logic start = 1'b0;
  logic busy, done, done_pulse, req_valid, resp_ready;
  logic req_ready = 1'b0;
  logic resp_valid = 1'b0;
  logic [15:0] resp_sad = '0;
  logic [5:0] req_x, req_y, best_x, best_y;
  logic [15:0] best_sad;

  int n_tests = 0;
  int n_fail = 0;
  int n_req = 0;
  int n_pulse = 0;

  always #4 clk = ~clk;

  bm_search_seq uut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .start(start), .busy(busy), .done(done),
    .done_pulse(done_pulse), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_sad(resp_sad), .best_x(best_x),
    .best_y(best_y), .best_sad(best_sad)
  );

  function automatic logic [15:0] ins(input logic [1:0] op, input int dx, input int dy);
    logic [5:0] x6, y6;
    x6 = 6'(dx);
    y6 = 6'(dy);
    return {op, 2'b00, x6, y6};
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int cost(input int x, input int y);
    return 4 * iabs(x - 3) + 4 * iabs(y + 2) + 7;
  endfunction

  typedef struct packed {
    logic [0:4][15:0] prog;
    logic [7:0]       ex;
    logic [7:0]       ey;
    logic [15:0]      esad;
    logic [3:0]       ereq;
  } scen_t;

  localparam logic [15:0] K = 16'h4000;
  localparam logic [15:0] H = 16'h8000;

  localparam scen_t SCEN [11] = '{
    '{ {ins(0,0,0),  ins(0,1,0),  K, H, H},                      8'd1,   8'd0,   16'd23,  4'd2 },
    '{ {ins(0,2,0),  ins(0,0,-1), K, H, H},                      8'd2,   8'd0,   16'd19,  4'd2 },
    '{ {ins(0,4,0),  K, ins(0,-1,-2), H, H},                     8'd4,   8'd0,   16'd19,  4'd2 },
    '{ {ins(0,3,-2), K, ins(0,0,0), K, H},                       8'd3,  -8'sd2,  16'd7,   4'd2 },
    '{ {ins(0,10,0), K, ins(0,-7,-2), K, H},                     8'd3,  -8'sd2,  16'd7,   4'd2 },
    '{ {ins(0,17,0), ins(0,-16,16), K, H, H},                   -8'sd16, 8'd16,  16'd155, 4'd1 },
    '{ {ins(0,16,0), K, ins(0,1,0), K, H},                       8'd16,  8'd0,   16'd67,  4'd1 },
    '{ {K, H, H, H, H},                                          8'd0,   8'd0,   16'hFFFF, 4'd0 },
    '{ {ins(0,1,0),  ins(3,5,5), K, H, H},                       8'd1,   8'd0,   16'd23,  4'd1 },
    '{ {ins(0,1,0) | 16'h1000, ins(0,2,0), K, H, H},             8'd2,   8'd0,   16'd19,  4'd1 },
    '{ {ins(0,3,0),  ins(0,5,-2), K, H, H},                      8'd3,   8'd0,   16'd15,  4'd2 }
  };

  // SAD engine model with varying stalls, driven on the falling edge
  initial begin
    int qdel, rdel, cx, cy;
    bit pend;
    qdel = 1; rdel = 0; pend = 0; cx = 0; cy = 0;
    forever begin
      @(negedge clk);
      if (resp_valid) resp_valid = 1'b0;
      else if (pend) begin
        if (rdel == 0) begin
          resp_valid = 1'b1;
          resp_sad = 16'(cost(cx, cy));
          pend = 0;
        end else rdel--;
      end
      if (req_ready) begin
        req_ready = 1'b0;
        pend = 1;
        rdel = n_req % 2;
      end else if (req_valid) begin
        if (qdel == 0) begin
          req_ready = 1'b1;
          cx = int'($signed(req_x));
          cy = int'($signed(req_y));
          n_req++;
          qdel = n_req % 3;
        end else qdel--;
      end
    end
  end

  always @(negedge clk) if (done_pulse) n_pulse++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_word(input int addr, input logic [15:0] w);
    @(negedge clk);
    prog_we = 1'b1;
    prog_addr = 6'(addr);
    prog_data = w;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int k;
    k = 0;
    while (!done && k < 3000) begin
      @(negedge clk);
      k++;
    end
    check(done == 1'b1, "R7 done raised", int'(done), 1);
  endtask

  task automatic check_result(input string tag, input int ex, input int ey, input int es);
    check(int'($signed(best_x)) == ex, {tag, " x"}, int'($signed(best_x)), ex);
    check(int'($signed(best_y)) == ey, {tag, " y"}, int'($signed(best_y)), ey);
    check(int'(best_sad) == es, {tag, " sad"}, int'(best_sad), es);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: state after reset
    check(busy == 1'b0 && done == 1'b0, "R10 idle after reset", int'({busy, done}), 0);
    check(req_valid == 1'b0 && resp_ready == 1'b0, "R10 handshakes low", int'({req_valid, resp_ready}), 0);
    check_result("R10 reset results", 0, 0, 65535);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R3 R4 R5 R6 R9 R11 and R2 (results reset per start)
    for (int i = 0; i < 11; i++) begin
      int base, pb;
      for (int j = 0; j < 5; j++) write_word(j, SCEN[i].prog[j]);
      base = n_req;
      pb = n_pulse;
      pulse_start();
      check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
      wait_done();
      @(negedge clk);
      check_result($sformatf("R6 scenario %0d", i),
                   int'($signed(SCEN[i].ex)), int'($signed(SCEN[i].ey)), int'(SCEN[i].esad));
      check(n_req - base == int'(SCEN[i].ereq), $sformatf("R4 R11 requests scenario %0d", i),
            n_req - base, int'(SCEN[i].ereq));
      check(n_pulse - pb == 1, "R7 one done pulse", n_pulse - pb, 1);
      check(busy == 1'b0, "R7 busy low after halt", int'(busy), 0);
    end

    // R8: program without halt ends after address 63
    begin
      int base;
      write_word(0, ins(0, 1, 1));
      for (int j = 1; j < 64; j++) write_word(j, K);
      base = n_req;
      pulse_start();
      wait_done();
      @(negedge clk);
      check_result("R8 no halt", 1, 1, 27);
      check(n_req - base == 1, "R8 requests", n_req - base, 1);
    end

    // R2: start during a run is ignored
    begin
      int base;
      for (int j = 0; j < 5; j++) write_word(j, SCEN[4].prog[j]);
      base = n_req;
      pulse_start();
      repeat (3) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      @(negedge clk);
      check(n_req - base == 2, "R2 start while busy ignored", n_req - base, 2);
      check_result("R2 start while busy results", 3, -2, 7);
      check(done == 1'b1, "R7 done held until next start", int'(done), 1);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule